// File: doc/BRIEF.md
# Serial Configuration Register Interface

This block takes configuration words from a three-wire serial bus (serial clock, serial data and a latch strobe) and stores them in a bank of eight addressable control registers. All three bus lines are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and its edges are found in the system clock domain. Bits enter a 24-bit shift register, most significant bit first, on each rising serial clock. A rising latch strobe then commits the 21-bit payload to the register named by the three lowest word bits, but only when exactly 24 serial clocks have arrived since the previous latch. Any other count discards the word and raises a one-cycle error pulse.

The stored fields drive the rest of the device. A control register picks receive or transmit operation. Two registers hold the per-section power enables, one set for receive and one for transmit. Four registers hold the synthesiser divide and reference ratios. A control bit lets an external mode pin take over the receive/transmit choice, so the device switches configuration and power set without a new serial write. A combined lock output gates an external lock indication with either the receive or the transmit lock, chosen by a control bit. Every stored bit is also exported unchanged for the analog functions that sit outside this block.

Top module: `serial_cfg_if`

## Requirements
- R1: A word is shifted in MSB first, one bit per rising serial clock. On the latch rising edge after exactly 24 serial clocks, word bits [23:3] are written to the register whose address is word bits [2:0]. That register appears at regs_o[addr*21 +: 21], and no other register changes.
- R2: A latch rising edge after any other number of serial clocks (fewer or more than 24) discards the word and leaves every register unchanged. frame_err_o is high for exactly one system clock cycle. The next correctly framed word commits normally.
- R3: After reset every register is zero. tx_active_o is 0 (receive), pwr_en_o is all zero, div_ratio_o and ref_ratio_o are zero, lock_o is 0 and frame_err_o is 0.
- R4: When control register 4 bit 1 is 0, tx_active_o equals control register 4 bit 0 (1 = transmit, 0 = receive).
- R5: When control register 4 bit 1 is 1, tx_active_o follows the synchronised mode_pin. When that bit is 0, mode_pin has no effect.
- R6: pwr_en_o equals register 5 bits [5:0] in receive and register 6 bits [5:0] in transmit.
- R7: div_ratio_o equals register 0 bits [17:0] in receive and register 1 bits [17:0] in transmit. ref_ratio_o equals register 2 bits [14:0] in receive and register 3 bits [14:0] in transmit.
- R8: lock_o is ext_lock_i AND rx_lock_i when control register 4 bit 2 is 0, and ext_lock_i AND tx_lock_i when it is 1.
- R9: Serial clock edges that arrive while the latch line is high are neither shifted nor counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bus clock (asynchronous) |
| ser_dat | input | 1 | Serial bus data (asynchronous) |
| ser_lat | input | 1 | Serial bus latch strobe (asynchronous) |
| mode_pin | input | 1 | External receive/transmit select (asynchronous) |
| rx_lock_i | input | 1 | Receive synthesiser lock, synchronous to clk |
| tx_lock_i | input | 1 | Transmit synthesiser lock, synchronous to clk |
| ext_lock_i | input | 1 | External synthesiser lock, synchronous to clk |
| tx_active_o | output | 1 | 1 = transmit configuration active |
| pwr_en_o | output | 6 | Active per-section power enables |
| div_ratio_o | output | 18 | Active synthesiser divide ratio |
| ref_ratio_o | output | 15 | Active reference divide ratio |
| lock_o | output | 1 | Combined lock indication |
| frame_err_o | output | 1 | One-cycle pulse on a rejected word |
| regs_o | output | 168 | All eight 21-bit registers, register n at [n*21 +: 21] |

## Verification
On every cycle the assertions check several properties. The error pulse never lasts longer than one cycle and never coincides with a commit. The bit counter stays within its saturation bound. No register moves unless a commit was issued. The active mode tracks the pin whenever pin control is enabled. The lock output never rises without the external lock. Reset leaves the outputs in receive with power off. Only the bench scenarios can show that the payload lands in the addressed slot in MSB-first order. They also show that short and long words are rejected and the following good word is accepted, that clocks during a high latch are ignored, and that power, divide and lock selections follow the written fields.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  // register addresses whose fields are decoded inside the block
  localparam int unsigned A_RX_DIV  = 0;
  localparam int unsigned A_TX_DIV  = 1;
  localparam int unsigned A_RX_REF  = 2;
  localparam int unsigned A_TX_REF  = 3;
  localparam int unsigned A_CTRL    = 4;
  localparam int unsigned A_RX_PWR  = 5;
  localparam int unsigned A_TX_PWR  = 6;
  // control register bit positions
  localparam int unsigned C_TX_SEL  = 0;
  localparam int unsigned C_PIN_EN  = 1;
  localparam int unsigned C_LOCK_TX = 2;

  typedef struct packed {
    logic tx_sel;
    logic pin_en;
    logic lock_tx;
  } ctrl_t;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              slat_s,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o,
  output logic              err_o
);
  localparam int unsigned CNT_MAX = WORD_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic              sclk_d, slat_d;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              sclk_rise, slat_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign slat_rise = slat_s & ~slat_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      slat_d   <= 1'b0;
      shreg    <= '0;
      cnt      <= '0;
      commit_o <= 1'b0;
      err_o    <= 1'b0;
      word_o   <= '0;
    end else begin
      sclk_d   <= sclk_s;
      slat_d   <= slat_s;
      commit_o <= 1'b0;
      err_o    <= 1'b0;
      if (slat_rise) begin
        if (cnt == CNT_W'(WORD_W)) begin
          commit_o <= 1'b1;
          word_o   <= shreg;
        end else begin
          err_o <= 1'b1;
        end
        cnt <= '0;
      end else if (sclk_rise && !slat_s) begin
        shreg <= {shreg[WORD_W-2:0], sdat_s};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end

  a_r2_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
  a_r1_commit_xor_err: assert property (@(posedge clk) disable iff (rst)
    !(commit_o && err_o));
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/scfg_regbank.sv
module scfg_regbank #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned PAY_W  = 21
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [PAY_W-1:0]              data_i,
  output logic [(2**ADDR_W)*PAY_W-1:0]  regs_o
);
  localparam int unsigned NREG = 2**ADDR_W;

  logic [PAY_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NREG); i++) mem[i] <= '0;
    end else if (wr_i) begin
      mem[addr_i] <= data_i;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[g*PAY_W +: PAY_W] = mem[g];
  end

  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(regs_o));
endmodule

// File: rtl/scfg_decode.sv
module scfg_decode
  import scfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned PAY_W  = 21,
  parameter int unsigned PWR_N  = 6,
  parameter int unsigned DIV_W  = 18,
  parameter int unsigned REF_W  = 15
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [(2**ADDR_W)*PAY_W-1:0]  regs_i,
  input  logic                          mode_s,
  input  logic                          rx_lock_i,
  input  logic                          tx_lock_i,
  input  logic                          ext_lock_i,
  output logic                          tx_active_o,
  output logic [PWR_N-1:0]              pwr_en_o,
  output logic [DIV_W-1:0]              div_ratio_o,
  output logic [REF_W-1:0]              ref_ratio_o,
  output logic                          lock_o
);
  logic [PAY_W-1:0] ctrl_w;
  ctrl_t            ctrl;
  logic             sel_tx;

  assign ctrl_w       = regs_i[A_CTRL*PAY_W +: PAY_W];
  assign ctrl.tx_sel  = ctrl_w[C_TX_SEL];
  assign ctrl.pin_en  = ctrl_w[C_PIN_EN];
  assign ctrl.lock_tx = ctrl_w[C_LOCK_TX];
  assign sel_tx       = ctrl.pin_en ? mode_s : ctrl.tx_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_active_o <= 1'b0;
      pwr_en_o    <= '0;
      div_ratio_o <= '0;
      ref_ratio_o <= '0;
      lock_o      <= 1'b0;
    end else begin
      tx_active_o <= sel_tx;
      if (sel_tx) begin
        pwr_en_o    <= regs_i[A_TX_PWR*PAY_W +: PWR_N];
        div_ratio_o <= regs_i[A_TX_DIV*PAY_W +: DIV_W];
        ref_ratio_o <= regs_i[A_TX_REF*PAY_W +: REF_W];
      end else begin
        pwr_en_o    <= regs_i[A_RX_PWR*PAY_W +: PWR_N];
        div_ratio_o <= regs_i[A_RX_DIV*PAY_W +: DIV_W];
        ref_ratio_o <= regs_i[A_RX_REF*PAY_W +: REF_W];
      end
      lock_o <= ext_lock_i & (ctrl.lock_tx ? tx_lock_i : rx_lock_i);
    end
  end

  a_r5_pin_follow: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl.pin_en) |-> (tx_active_o == $past(mode_s)));
  a_r8_lock_needs_ext: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> $past(ext_lock_i));
  a_r3_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_active_o && pwr_en_o == '0));
endmodule

// File: rtl/serial_cfg_if.sv
module serial_cfg_if #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned PWR_N  = 6,
  parameter int unsigned DIV_W  = 18,
  parameter int unsigned REF_W  = 15,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   ser_clk,
  input  logic                                   ser_dat,
  input  logic                                   ser_lat,
  input  logic                                   mode_pin,
  input  logic                                   rx_lock_i,
  input  logic                                   tx_lock_i,
  input  logic                                   ext_lock_i,
  output logic                                   tx_active_o,
  output logic [PWR_N-1:0]                       pwr_en_o,
  output logic [DIV_W-1:0]                       div_ratio_o,
  output logic [REF_W-1:0]                       ref_ratio_o,
  output logic                                   lock_o,
  output logic                                   frame_err_o,
  output logic [(2**ADDR_W)*(WORD_W-ADDR_W)-1:0] regs_o
);
  localparam int unsigned PAY_W = WORD_W - ADDR_W;

  logic [3:0]        async_in, sync_out;
  logic              commit;
  logic [WORD_W-1:0] word;

  assign async_in = {mode_pin, ser_lat, ser_dat, ser_clk};

  scfg_sync #(.W(4), .STAGES(SYNC_N)) u_sync (
    .clk (clk), .rst (rst), .d_i (async_in), .q_o (sync_out)
  );

  scfg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sync_out[0]),
    .sdat_s   (sync_out[1]),
    .slat_s   (sync_out[2]),
    .commit_o (commit),
    .word_o   (word),
    .err_o    (frame_err_o)
  );

  scfg_regbank #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (commit),
    .addr_i (word[ADDR_W-1:0]),
    .data_i (word[WORD_W-1:ADDR_W]),
    .regs_o (regs_o)
  );

  scfg_decode #(
    .ADDR_W(ADDR_W), .PAY_W(PAY_W), .PWR_N(PWR_N), .DIV_W(DIV_W), .REF_W(REF_W)
  ) u_dec (
    .clk         (clk),
    .rst         (rst),
    .regs_i      (regs_o),
    .mode_s      (sync_out[3]),
    .rx_lock_i   (rx_lock_i),
    .tx_lock_i   (tx_lock_i),
    .ext_lock_i  (ext_lock_i),
    .tx_active_o (tx_active_o),
    .pwr_en_o    (pwr_en_o),
    .div_ratio_o (div_ratio_o),
    .ref_ratio_o (ref_ratio_o),
    .lock_o      (lock_o)
  );
endmodule

// File: tb/serial_cfg_if_bench.sv
module serial_cfg_if_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 0, ser_dat = 0, ser_lat = 0, mode_pin = 0;
  logic rx_lock_i = 0, tx_lock_i = 0, ext_lock_i = 0;
  logic         tx_active_o, lock_o, frame_err_o;
  logic [5:0]   pwr_en_o;
  logic [17:0]  div_ratio_o;
  logic [14:0]  ref_ratio_o;
  logic [167:0] regs_o;

  int checks = 0, fails = 0, err_pulses = 0;

  serial_cfg_if u_serial_cfg_if (.*);

  always #10 clk = ~clk;

  always @(negedge clk) if (!rst && frame_err_o) err_pulses++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic latch_pulse();
    ser_lat = 1; wait_clk(4); ser_lat = 0; wait_clk(10);
  endtask

  // send nbits of val, MSB first, then latch
  task automatic send_bits(logic [24:0] val, int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_dat = val[i]; wait_clk(4);
      ser_clk = 1;      wait_clk(4);
      ser_clk = 0;      wait_clk(4);
    end
    latch_pulse();
  endtask

  task automatic write_reg(int addr, logic [20:0] data);
    send_bits({1'b0, data, 3'(addr)}, 24);
  endtask

  function automatic logic [20:0] reg_of(int a);
    return regs_o[a*21 +: 21];
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R3 regs", 32'(regs_o == '0), 1);
    chk("R3 tx_active", 32'(tx_active_o), 0);
    chk("R3 pwr", 32'(pwr_en_o), 0);
    chk("R3 div", 32'(div_ratio_o), 0);
    chk("R3 lock/err", 32'({lock_o, frame_err_o}), 0);
  endtask

  task automatic t_write();
    write_reg(7, 21'h1A5C3E);
    @(negedge clk);
    chk("R1 reg7", 32'(reg_of(7)), 32'h1A5C3E);
    chk("R1 others untouched", 32'(regs_o[146:0]), 0);
    chk("R1 no err", 32'(err_pulses), 0);
  endtask

  task automatic t_bad_frames();
    send_bits({1'b0, 21'h0F0F0F, 3'd7}, 23);
    @(negedge clk);
    chk("R2 short kept", 32'(reg_of(7)), 32'h1A5C3E);
    chk("R2 short err pulse", 32'(err_pulses), 1);
    send_bits({1'b1, 21'h0F0F0F, 3'd7}, 25);
    @(negedge clk);
    chk("R2 long kept", 32'(reg_of(7)), 32'h1A5C3E);
    chk("R2 long err pulse", 32'(err_pulses), 2);
    write_reg(7, 21'h000ABC);
    @(negedge clk);
    chk("R2 recovery", 32'(reg_of(7)), 32'h000ABC);
    chk("R2 no extra err", 32'(err_pulses), 2);
  endtask

  task automatic t_latch_high_clocks();
    ser_lat = 1; wait_clk(4);
    for (int k = 0; k < 3; k++) begin
      ser_clk = 1; wait_clk(4); ser_clk = 0; wait_clk(4);
    end
    ser_lat = 0; wait_clk(10);
    write_reg(7, 21'h155555);
    @(negedge clk);
    chk("R9 word commits", 32'(reg_of(7)), 32'h155555);
    chk("R9 only latch err", 32'(err_pulses), 3);
  endtask

  task automatic t_select();
    write_reg(0, 21'h12345);
    write_reg(1, 21'h2ABCD);
    write_reg(2, 21'h1234);
    write_reg(3, 21'h7001);
    write_reg(5, 21'h15);
    write_reg(6, 21'h2A);
    @(negedge clk);
    chk("R4 rx mode", 32'(tx_active_o), 0);
    chk("R6 rx pwr", 32'(pwr_en_o), 32'h15);
    chk("R7 rx div", 32'(div_ratio_o), 32'h12345);
    chk("R7 rx ref", 32'(ref_ratio_o), 32'h1234);
    write_reg(4, 21'h1);
    @(negedge clk);
    chk("R4 tx mode", 32'(tx_active_o), 1);
    chk("R6 tx pwr", 32'(pwr_en_o), 32'h2A);
    chk("R7 tx div", 32'(div_ratio_o), 32'h2ABCD);
    chk("R7 tx ref", 32'(ref_ratio_o), 32'h7001);
  endtask

  task automatic t_pin();
    write_reg(4, 21'h2);
    mode_pin = 0; wait_clk(6); @(negedge clk);
    chk("R5 pin low rx", 32'(tx_active_o), 0);
    mode_pin = 1; wait_clk(6); @(negedge clk);
    chk("R5 pin high tx", 32'(tx_active_o), 1);
    chk("R5 pin power swap", 32'(pwr_en_o), 32'h2A);
    write_reg(4, 21'h0);
    @(negedge clk);
    chk("R5 pin ignored", 32'(tx_active_o), 0);
    chk("R5 pin ignored pwr", 32'(pwr_en_o), 32'h15);
    mode_pin = 0;
  endtask

  task automatic t_lock();
    rx_lock_i = 1; tx_lock_i = 0; ext_lock_i = 1; wait_clk(3); @(negedge clk);
    chk("R8 rx lock", 32'(lock_o), 1);
    ext_lock_i = 0; wait_clk(3); @(negedge clk);
    chk("R8 ext gates", 32'(lock_o), 0);
    ext_lock_i = 1;
    write_reg(4, 21'h4);
    @(negedge clk);
    chk("R8 tx sel low", 32'(lock_o), 0);
    tx_lock_i = 1; rx_lock_i = 0; wait_clk(3); @(negedge clk);
    chk("R8 tx sel high", 32'(lock_o), 1);
  endtask

  initial begin
    wait_clk(5);
    rst = 0;
    wait_clk(3);
    t_reset();
    t_write();
    t_bad_frames();
    t_latch_high_clocks();
    t_select();
    t_pin();
    t_lock();
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule